// File: doc/BRIEF.md
# Stepped Repeated-Subtraction Divider

This block divides one unsigned operand by another by subtracting the divisor again and again from a running remainder, counting each successful subtraction into the quotient. A single clocked state machine holds three phases: an idle phase that loads the operands, a calculation phase that does one subtraction per advance, and a finished phase that holds the result. The datapath registers are updated from the same case statement that moves the phase register.

Only the calculation phase depends on a step-enable input. When the enable is high on every clock the division runs at full clock rate. When the enable is pulsed, the division advances one subtraction per pulse. This lets a debugger watch each intermediate value. The clock itself is never gated. A build option ties the enable high inside the block for free-running use. A divisor of zero is not trapped: the block stays in the calculation phase and the quotient counter wraps.

Top module: `divstep_core`

## Requirements
- R1: On a synchronous reset the block enters the idle phase. After that edge `ph_idle`=1, `ph_calc`=0, `ph_fin`=0, `quotient`=0 and `remainder`=0.
- R2: Exactly one of `ph_idle`, `ph_calc` and `ph_fin` is high in every cycle.
- R3: In the idle phase every clock loads the dividend and divisor inputs and clears the quotient. A `start` seen in idle moves the block to the calculation phase at that edge, with the operands sampled at that edge. `start` has no effect in the other phases.
- R4: In the calculation phase with the step enable high and remainder >= divisor, one edge sets the remainder to remainder - divisor and the quotient to quotient + 1. The block stays in the calculation phase.
- R5: In the calculation phase with the step enable high and remainder < divisor, the next edge moves the block to the finished phase with quotient and remainder unchanged. With the enable held high, `ph_fin` rises q+1 edges after the start edge, where q is the true quotient.
- R6: In the calculation phase with the step enable low, the quotient, the remainder and the phase all hold. `ack` has no effect there.
- R7: In the finished phase the outputs hold while `ack` is low. `ack` returns the block to idle at the next edge. `ack` has no effect in idle.
- R8: With a zero divisor the block never leaves the calculation phase. The quotient counts once per enabled edge and wraps from 2^WIDTH-1 to 0.
- R9: With FREE_RUN=1 the step input is ignored and the calculation phase advances on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division (used in idle only) |
| ack | input | 1 | Release the result (used in finished only) |
| step | input | 1 | Single-clock advance enable for the calculation phase |
| dividend | input | WIDTH | Dividend operand |
| divisor | input | WIDTH | Divisor operand |
| quotient | output | WIDTH | Quotient counter |
| remainder | output | WIDTH | Running remainder, final remainder in the finished phase |
| ph_idle | output | 1 | Idle phase indicator |
| ph_calc | output | 1 | Calculation phase indicator |
| ph_fin | output | 1 | Finished phase indicator |

## Verification
All outputs come straight from registers. A `start`, `ack` or enabled step therefore shows at the ports one edge after the edge that samples it, and a full-speed result appears q+1 edges after the start edge. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each read falls exactly one rising edge after its cause. For full-speed runs it counts edges from the start edge until `ph_fin` rises and compares the count with q+1. For stepped runs it checks the outputs after every single pulse and after idle cycles between pulses.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
  // one-hot phase code: bit 0 idle, bit 1 calculation, bit 2 finished
  typedef enum logic [2:0] {
    PH_IDLE = 3'b001,
    PH_CALC = 3'b010,
    PH_FIN  = 3'b100
  } phase_t;
endpackage

// File: rtl/divstep_sub_unit.sv
module divstep_sub_unit #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] dvs,
  input  logic [WIDTH-1:0] cnt,
  output logic             fits,
  output logic [WIDTH-1:0] diff,
  output logic [WIDTH-1:0] cnt_inc
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    fits    = (acc >= dvs);
    diff    = acc - dvs;
    cnt_inc = cnt + ONE;
  end
endmodule

// File: rtl/divstep_step_gate.sv
module divstep_step_gate #(
  parameter bit FREE_RUN = 1'b0
) (
  input  logic step_in,
  output logic step_ok
);
  generate
    if (FREE_RUN) begin : g_free
      logic unused_step;
      assign unused_step = step_in;
      assign step_ok = 1'b1;
    end else begin : g_gated
      assign step_ok = step_in;
    end
  endgenerate
endmodule

// File: rtl/divstep_core.sv
module divstep_core
  import divstep_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter bit FREE_RUN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             ack,
  input  logic             step,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             ph_idle,
  output logic             ph_calc,
  output logic             ph_fin
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  phase_t           phase;
  logic [WIDTH-1:0] acc;
  logic [WIDTH-1:0] dvs;
  logic [WIDTH-1:0] cnt;
  logic             fits;
  logic [WIDTH-1:0] diff;
  logic [WIDTH-1:0] cnt_inc;
  logic             step_ok;

  divstep_sub_unit #(.WIDTH(WIDTH)) u_sub (
    .acc     (acc),
    .dvs     (dvs),
    .cnt     (cnt),
    .fits    (fits),
    .diff    (diff),
    .cnt_inc (cnt_inc)
  );

  divstep_step_gate #(.FREE_RUN(FREE_RUN)) u_gate (
    .step_in (step),
    .step_ok (step_ok)
  );

  // control and datapath share one case; registers not named in a branch hold
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      acc   <= ZERO;
      dvs   <= ZERO;
      cnt   <= ZERO;
    end else begin
      case (phase)
        PH_IDLE: begin
          acc <= dividend;
          dvs <= divisor;
          cnt <= ZERO;
          if (start) phase <= PH_CALC;
        end
        PH_CALC: begin
          if (step_ok) begin
            if (fits) begin
              acc <= diff;
              cnt <= cnt_inc;
            end else begin
              phase <= PH_FIN;
            end
          end
        end
        PH_FIN: begin
          if (ack) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign quotient  = cnt;
  assign remainder = acc;
  assign ph_idle   = phase[0];
  assign ph_calc   = phase[1];
  assign ph_fin    = phase[2];

  // R2: indicators stay one-hot
  a_r2_one_phase: assert property (@(posedge clk) disable iff (rst)
    $countones({ph_idle, ph_calc, ph_fin}) == 1);

  // R3: start in idle enters calculation with a cleared quotient
  a_r3_start_enters: assert property (@(posedge clk) disable iff (rst)
    (ph_idle && start) |=> (ph_calc && quotient == ZERO));

  // R4: an enabled step with room subtracts and counts
  a_r4_sub_step: assert property (@(posedge clk) disable iff (rst)
    (ph_calc && step_ok && remainder >= dvs) |=>
      (ph_calc && remainder == $past(remainder) - $past(dvs)
               && quotient == $past(quotient) + WIDTH'(1)));

  // R5: an enabled step without room finishes and keeps the result
  a_r5_exit: assert property (@(posedge clk) disable iff (rst)
    (ph_calc && step_ok && remainder < dvs) |=>
      (ph_fin && $stable(remainder) && $stable(quotient)));

  // R6: no step means no change in calculation
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (ph_calc && !step_ok) |=>
      (ph_calc && $stable(remainder) && $stable(quotient)));

  // R7: finished holds until ack, ack returns to idle
  a_r7_fin_hold: assert property (@(posedge clk) disable iff (rst)
    (ph_fin && !ack) |=> (ph_fin && $stable(remainder) && $stable(quotient)));
  a_r7_ack_back: assert property (@(posedge clk) disable iff (rst)
    (ph_fin && ack) |=> ph_idle);

  // R8: a zero divisor never finishes
  a_r8_zero_spin: assert property (@(posedge clk) disable iff (rst)
    (ph_calc && dvs == ZERO) |=> ph_calc);
endmodule

// File: tb/sim_divstep_core.sv
module sim_divstep_core;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         ack = 1'b0;
  logic         step = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;

  logic [W-1:0] quo0, rem0, quo1, rem1;
  logic         idle0, calc0, fin0, idle1, calc1, fin1;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  divstep_core #(.WIDTH(W), .FREE_RUN(1'b0)) u0 (
    .clk(clk), .rst(rst), .start(start), .ack(ack), .step(step),
    .dividend(dividend), .divisor(divisor),
    .quotient(quo0), .remainder(rem0),
    .ph_idle(idle0), .ph_calc(calc0), .ph_fin(fin0)
  );

  // free-running variant, its step input held low
  divstep_core #(.WIDTH(W), .FREE_RUN(1'b1)) u1 (
    .clk(clk), .rst(rst), .start(start), .ack(ack), .step(1'b0),
    .dividend(dividend), .divisor(divisor),
    .quotient(quo1), .remainder(rem1),
    .ph_idle(idle1), .ph_calc(calc1), .ph_fin(fin1)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // phase word from u0: 1 idle, 2 calc, 4 fin
  function automatic int ph0();
    return {29'd0, fin0, calc0, idle0};
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic do_reset();
    start = 0; ack = 0; step = 0;
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 phase", ph0(), 1);
    check("R1 quotient", quo0, 0);
    check("R1 remainder", rem0, 0);
    check("R2 onehot", $countones({idle0, calc0, fin0}), 1);
  endtask

  task automatic full_speed(input int a, input int b);
    int n;
    do_reset();
    step = 1; dividend = W'(a); divisor = W'(b); start = 1;
    tick(); start = 0;
    check("R3 enter calc", ph0(), 2);
    n = 0;
    while (!fin0 && n < 400) begin tick(); n++; end
    check("R5 edges to done", n, a / b + 1);
    check("R5 quotient", quo0, a / b);
    check("R5 remainder", rem0, a % b);
    dividend = W'(a + 1); start = 1; tick(); start = 0;
    check("R7 hold quotient", quo0, a / b);
    check("R3 start ignored in done", ph0(), 4);
    ack = 1; tick(); ack = 0;
    check("R7 ack to idle", ph0(), 1);
    ack = 1; tick(); ack = 0;
    check("R7 ack ignored in idle", ph0(), 1);
    step = 0;
  endtask

  task automatic t_full_speed();
    full_speed(88, 4);
    full_speed(200, 7);
    full_speed(5, 9);
    full_speed(255, 1);
    full_speed(0, 5);
  endtask

  task automatic t_single_step();
    do_reset();
    step = 0; dividend = 8'd50; divisor = 8'd20; start = 1;
    tick(); start = 0;
    dividend = 8'd3;
    tick(); tick(); ack = 1; tick(); ack = 0;
    check("R6 phase held", ph0(), 2);
    check("R6 remainder held", rem0, 50);
    check("R6 quotient held", quo0, 0);
    step = 1; tick(); step = 0;
    check("R4 remainder after step", rem0, 30);
    check("R4 quotient after step", quo0, 1);
    tick();
    check("R6 hold between steps", rem0, 30);
    step = 1; tick(); step = 0;
    check("R4 second step", rem0, 10);
    check("R4 second quotient", quo0, 2);
    check("R4 still calc", ph0(), 2);
    step = 1; tick(); step = 0;
    check("R5 done after exit step", ph0(), 4);
    check("R5 final remainder", rem0, 10);
    check("R5 final quotient", quo0, 2);
  endtask

  task automatic t_div_zero();
    do_reset();
    step = 1; dividend = 8'd3; divisor = 8'd0; start = 1;
    tick(); start = 0;
    for (int k = 0; k < 255; k++) tick();
    check("R8 quotient at 255", quo0, 255);
    tick();
    check("R8 quotient wraps", quo0, 0);
    for (int k = 0; k < 4; k++) tick();
    check("R8 quotient after wrap", quo0, 4);
    check("R8 never done", ph0(), 2);
    check("R8 remainder kept", rem0, 3);
    step = 0;
  endtask

  task automatic t_free_run();
    do_reset();
    step = 0; dividend = 8'd100; divisor = 8'd9; start = 1;
    tick(); start = 0;
    for (int k = 0; k < 12; k++) tick();
    check("R9 free-run done", {29'd0, fin1, calc1, idle1}, 4);
    check("R9 free-run quotient", quo1, 11);
    check("R9 free-run remainder", rem1, 1);
    check("R6 gated copy held", quo0, 0);
  endtask

  initial begin
    t_reset();
    t_full_speed();
    t_single_step();
    t_div_zero();
    t_free_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule